// File: doc/BRIEF.md
# TDM Status Stream Transmitter

This block places up to four short status words on a shared serial output line that follows a TDM frame. The words are a 10-bit battery voltage, an 8-bit die temperature, an 8-bit limiter gain reduction and an 8-bit boost sync value. The frame is cut into 8-bit slots, and each word has its own slot index and enable. A word is captured once at every frame start, so the whole frame carries one coherent set of values. The bit clock runs the block, and a rising frame sync starts each frame.

Bits that no enabled word covers are either driven low or released, depending on a fill selection. In the released case the output enable goes low, and a keeper request output tells the pad when to hold the line level. The keeper can hold for the bit period after a word's last bit, for only half of that period, or all the time. A transmit-edge selection decides whether the output changes after the rising or the falling bit-clock edge. When several systems share the line, each one transmits in its own slots.

Top module: `tdm_status_tx`

## Requirements
- R1: A frame starts at the rising bit-clock edge that first samples frame sync high after it was low. The bit period that follows that edge is frame position 0. All four stream values are captured at that edge, and a change of the value inputs later in the frame does not alter what is sent.
- R2: Data bit 0 of the frame falls at frame position `tx_offset` (0 to 7). Positions before it carry only fill.
- R3: A stream with slot index k (0 to 63) sends its MSB at data bit 8k. The remaining bits follow MSB first, one per bit period.
- R4: With `volt_wide` = 0, the voltage stream sends only bits 9..2 of the voltage value, in one 8-bit slot.
- R5: With `volt_wide` = 1, the voltage stream sends 16 bits over two slots. The 16 bits are the 10-bit value followed by six zeros.
- R6: The temperature, gain and boost streams each send their 8-bit value in one slot.
- R7: `stream_en` bit 0 enables voltage, bit 1 temperature, bit 2 gain and bit 3 boost. A disabled stream sends nothing, and its bits carry fill.
- R8: Bits not covered by an enabled stream are fill. With `fill_hiz` = 0, fill is `sdout` = 0 with `sdout_oe` = 1. With `fill_hiz` = 1, fill is `sdout_oe` = 0 with `sdout` = 0.
- R9: Where enabled streams overlap, the stream with the lowest number wins. The order from highest priority is voltage, temperature, gain, boost.
- R10: A new frame start ends any transmission still in progress. The new frame begins at position 0 with no leftover bits.
- R11: With `tx_fall` = 0, the outputs move to the next position right after the rising bit-clock edge. With `tx_fall` = 1, they move half a cycle later, right after the falling edge.
- R12: With `keep_en` = 0, `keeper_on` is 0. With `keep_en` = 1 and `keep_always` = 1, `keeper_on` is 1. Otherwise `keeper_on` is 1 only in the bit period right after a winning stream's last bit, and only while `sdout_oe` is 0. With `keep_half` = 1, this is narrowed to the first half of that bit period.
- R13: From reset until the first frame start, `sdout` and `sdout_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; a rising level sampled on bclk starts a frame |
| tx_fall | input | 1 | 0: change output after rising edge; 1: after falling edge (usual default 1) |
| tx_offset | input | 3 | Bit periods from frame start to data bit 0 (usual default 1) |
| volt_idx | input | 6 | Slot index of the voltage stream (usual default 4) |
| temp_idx | input | 6 | Slot index of the temperature stream (usual default 5) |
| gain_idx | input | 6 | Slot index of the gain stream (usual default 6) |
| boost_idx | input | 6 | Slot index of the boost sync stream (usual default 7) |
| stream_en | input | 4 | Per-stream enables: voltage, temperature, gain, boost in bits 0..3 (usual default 0) |
| volt_wide | input | 1 | 0: 8-bit voltage slot; 1: 16-bit left-justified voltage |
| fill_hiz | input | 1 | 0: drive fill as 0; 1: release the line for fill (usual default 1) |
| keep_en | input | 1 | Keeper master enable (usual default 1) |
| keep_always | input | 1 | 1: keeper on at all times |
| keep_half | input | 1 | 1: hold the last bit for half a bit period only |
| volt_val | input | 10 | Battery voltage value |
| temp_val | input | 8 | Die temperature value |
| gain_val | input | 8 | Limiter gain reduction value |
| boost_val | input | 8 | Boost sync value |
| sdout | output | 1 | Serial data bit |
| sdout_oe | output | 1 | Output enable for the pad driver |
| keeper_on | output | 1 | Keeper request for the pad |

## Verification
If the frame position counter is wrong, every stream slides by the same amount. The first mismatch then shows on `sdout` at a stream's first bit, within the same frame. A wrong winner among overlapping streams, or a wrong captured value, shows as wrong data bits inside the affected slot. A wrong end-of-word flag shows on `keeper_on` one bit period after that slot's last bit. Edge selection faults show as a half-cycle lag, or as a missing half-cycle lag, when the outputs are sampled in both bit-clock phases.

// File: rtl/tdm_status_tx.sv
module tdm_status_tx #(
  parameter int SLOT_W = 8,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 3,
  parameter int VOLT_W = 10,
  parameter int VAL_W  = 8,
  parameter int POS_W  = 10
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              tx_fall,
  input  logic [OFF_W-1:0]  tx_offset,
  input  logic [IDX_W-1:0]  volt_idx,
  input  logic [IDX_W-1:0]  temp_idx,
  input  logic [IDX_W-1:0]  gain_idx,
  input  logic [IDX_W-1:0]  boost_idx,
  input  logic [3:0]        stream_en,
  input  logic              volt_wide,
  input  logic              fill_hiz,
  input  logic              keep_en,
  input  logic              keep_always,
  input  logic              keep_half,
  input  logic [VOLT_W-1:0] volt_val,
  input  logic [VAL_W-1:0]  temp_val,
  input  logic [VAL_W-1:0]  gain_val,
  input  logic [VAL_W-1:0]  boost_val,
  output logic              sdout,
  output logic              sdout_oe,
  output logic              keeper_on
);
  localparam int WIDE_W = 2 * SLOT_W;
  localparam logic [POS_W-1:0] POS_END = '1;

  logic              fs_q, started, lsb_q;
  logic [POS_W-1:0]  pos;
  logic [VOLT_W-1:0] volt_q;
  logic [VAL_W-1:0]  temp_q, gain_q, boost_q;

  wire frame_go = fsync & ~fs_q;
  wire [POS_W-1:0] off_ext = POS_W'(tx_offset);
  wire past_off = pos >= off_ext;
  wire [POS_W-1:0] dpos = pos - off_ext;

  logic [3:0][IDX_W-1:0]  idx;
  logic [3:0][WIDE_W-1:0] word;
  logic [3:0][POS_W-1:0]  len;
  logic [3:0] hit, bitv, last;

  assign idx = {boost_idx, gain_idx, temp_idx, volt_idx};

  assign word[0] = volt_wide ? {volt_q, {(WIDE_W-VOLT_W){1'b0}}}
                             : {volt_q[VOLT_W-1 -: SLOT_W], {SLOT_W{1'b0}}};
  assign word[1] = {temp_q,  {(WIDE_W-VAL_W){1'b0}}};
  assign word[2] = {gain_q,  {(WIDE_W-VAL_W){1'b0}}};
  assign word[3] = {boost_q, {(WIDE_W-VAL_W){1'b0}}};

  assign len[0] = volt_wide ? POS_W'(WIDE_W) : POS_W'(SLOT_W);
  assign len[1] = POS_W'(SLOT_W);
  assign len[2] = POS_W'(SLOT_W);
  assign len[3] = POS_W'(SLOT_W);

  for (genvar i = 0; i < 4; i++) begin : g_str
    logic [POS_W-1:0]  st, rel;
    logic [WIDE_W-1:0] sh;
    assign st      = POS_W'(idx[i]) * POS_W'(SLOT_W);
    assign rel     = dpos - st;
    assign sh      = word[i] << rel;
    assign hit[i]  = started & stream_en[i] & past_off & (dpos >= st) & (rel < len[i]);
    assign bitv[i] = sh[WIDE_W-1];
    assign last[i] = rel == (len[i] - POS_W'(1));
  end

  logic win_hit, win_bit, win_last;
  always_comb begin
    win_hit  = 1'b0;
    win_bit  = 1'b0;
    win_last = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      if (hit[i]) begin
        win_hit  = 1'b1;
        win_bit  = bitv[i];
        win_last = last[i];
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      started <= 1'b0;
      lsb_q   <= 1'b0;
      pos     <= POS_END;
      volt_q  <= '0;
      temp_q  <= '0;
      gain_q  <= '0;
      boost_q <= '0;
    end else begin
      fs_q <= fsync;
      if (frame_go) begin
        started <= 1'b1;
        lsb_q   <= 1'b0;
        pos     <= '0;
        volt_q  <= volt_val;
        temp_q  <= temp_val;
        gain_q  <= gain_val;
        boost_q <= boost_val;
      end else begin
        lsb_q <= win_last;
        if (pos != POS_END) pos <= pos + POS_W'(1);
      end
    end
  end

  wire sd_c  = win_hit & win_bit;
  wire oe_c  = started & (win_hit | ~fill_hiz);
  wire aft_c = lsb_q;

  logic sd_n, oe_n, aft_n;
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sd_n  <= 1'b0;
      oe_n  <= 1'b0;
      aft_n <= 1'b0;
    end else begin
      sd_n  <= sd_c;
      oe_n  <= oe_c;
      aft_n <= aft_c;
    end
  end

  wire aft_m   = tx_fall ? aft_n : aft_c;
  wire half_ok = ~keep_half | (tx_fall ? ~bclk : bclk);

  assign sdout     = tx_fall ? sd_n : sd_c;
  assign sdout_oe  = tx_fall ? oe_n : oe_c;
  assign keeper_on = keep_en & (keep_always | (aft_m & ~sdout_oe & half_ok));
endmodule

// File: rtl/tdm_status_tx_chk.sv
module tdm_status_tx_chk (
  input logic bclk,
  input logic rst_n,
  input logic started,
  input logic fill_hiz,
  input logic keep_en,
  input logic keep_always,
  input logic sdout,
  input logic sdout_oe,
  input logic keeper_on
);
  p_idle_before_frame_r13: assert property (@(posedge bclk) disable iff (!rst_n)
    !started |-> (!sdout_oe && !sdout));

  p_data_needs_drive_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    sdout |-> sdout_oe);

  p_zero_fill_drives_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    (started && $past(started) && !fill_hiz && !$past(fill_hiz)) |-> sdout_oe);

  p_keeper_disabled_r12: assert property (@(posedge bclk) disable iff (!rst_n)
    !keep_en |-> !keeper_on);

  p_keeper_forced_r12: assert property (@(posedge bclk) disable iff (!rst_n)
    (keep_en && keep_always) |-> keeper_on);

  p_keeper_released_only_r12: assert property (@(posedge bclk) disable iff (!rst_n)
    (keeper_on && !keep_always) |-> !sdout_oe);
endmodule

bind tdm_status_tx tdm_status_tx_chk u_chk (
  .bclk(bclk), .rst_n(rst_n), .started(started), .fill_hiz(fill_hiz),
  .keep_en(keep_en), .keep_always(keep_always), .sdout(sdout),
  .sdout_oe(sdout_oe), .keeper_on(keeper_on)
);

// File: tb/sim_tdm_status_tx.sv
module sim_tdm_status_tx;
  localparam int PERIOD = 10;

  logic bclk = 1'b0, rst_n = 1'b0, fsync = 1'b0;
  logic tx_fall = 1'b1, volt_wide = 1'b0, fill_hiz = 1'b1;
  logic keep_en = 1'b1, keep_always = 1'b0, keep_half = 1'b0;
  logic [2:0] tx_offset = 3'd1;
  logic [5:0] volt_idx = 6'd4, temp_idx = 6'd5, gain_idx = 6'd6, boost_idx = 6'd7;
  logic [3:0] stream_en = 4'h0;
  logic [9:0] volt_val = '0;
  logic [7:0] temp_val = '0, gain_val = '0, boost_val = '0;
  logic sdout, sdout_oe, keeper_on;

  logic [9:0] mv;
  logic [7:0] mt, mg, mb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) bclk = ~bclk;

  tdm_status_tx u0 (
    .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .tx_fall(tx_fall), .tx_offset(tx_offset),
    .volt_idx(volt_idx), .temp_idx(temp_idx), .gain_idx(gain_idx), .boost_idx(boost_idx),
    .stream_en(stream_en), .volt_wide(volt_wide), .fill_hiz(fill_hiz), .keep_en(keep_en),
    .keep_always(keep_always), .keep_half(keep_half), .volt_val(volt_val),
    .temp_val(temp_val), .gain_val(gain_val), .boost_val(boost_val),
    .sdout(sdout), .sdout_oe(sdout_oe), .keeper_on(keeper_on)
  );

  // {hit, bit, last} of the winning stream at frame position p
  function automatic logic [2:0] ref_bit(int p);
    int d, st, ln;
    logic [15:0] w;
    if (p < int'(tx_offset)) return 3'b000;
    d = p - int'(tx_offset);
    for (int s = 0; s < 4; s++) begin
      case (s)
        0: begin ln = volt_wide ? 16 : 8; w = volt_wide ? {mv, 6'b0} : {mv[9:2], 8'h00}; st = int'(volt_idx) * 8; end
        1: begin ln = 8; w = {mt, 8'h00}; st = int'(temp_idx) * 8; end
        2: begin ln = 8; w = {mg, 8'h00}; st = int'(gain_idx) * 8; end
        default: begin ln = 8; w = {mb, 8'h00}; st = int'(boost_idx) * 8; end
      endcase
      if (stream_en[s] && d >= st && d < st + ln)
        return {1'b1, w[15 - (d - st)], (d - st) == ln - 1};
    end
    return 3'b000;
  endfunction

  // {sdout, sdout_oe, keeper_on}
  function automatic logic [2:0] expect_out(int p, bit half_ok);
    logic [2:0] h;
    logic oe, sd, aft, kp;
    h   = ref_bit(p);
    oe  = h[2] | !fill_hiz;
    sd  = h[2] & h[1];
    aft = (p > 0) ? ref_bit(p - 1)[0] : 1'b0;
    kp  = keep_en & (keep_always | (aft & !oe & (!keep_half | half_ok)));
    return {sd, oe, kp};
  endfunction

  task automatic check(string tag, int p, logic [2:0] exp);
    logic [2:0] got;
    got = {sdout, sdout_oe, keeper_on};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s pos %0d: sd/oe/keep got %b expected %b", tag, p, got, exp);
    end
  endtask

  // called between edges; frame starts at the next rising edge
  task automatic frame(int n, string tag, bit scramble);
    fsync = 1'b1;
    mv = volt_val; mt = temp_val; mg = gain_val; mb = boost_val;
    @(posedge bclk);
    for (int p = 0; p < n; p++) begin
      if (p > 0) @(posedge bclk);
      #2;
      if (p == 0) fsync = 1'b0;
      if (scramble && p == 1) begin
        volt_val = 10'($urandom); temp_val = 8'($urandom);
        gain_val = 8'($urandom); boost_val = 8'($urandom);
      end
      #1;
      if (p > 0) check(tag, p, expect_out(tx_fall ? p - 1 : p, !tx_fall));
      #4;
      check(tag, p, expect_out(p, tx_fall));
    end
  endtask

  task automatic set_vals(logic [9:0] v, logic [7:0] t, logic [7:0] g, logic [7:0] b);
    volt_val = v; temp_val = t; gain_val = g; boost_val = b;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge bclk);
    #2 rst_n = 1'b1;
    // R13: idle before the first frame
    stream_en = 4'hF;
    for (int i = 0; i < 3; i++) begin
      @(posedge bclk); #7;
      checks++;
      if ({sdout, sdout_oe, keeper_on} !== 3'b000) begin
        fails++;
        $display("FAIL R13: got %b expected 000", {sdout, sdout_oe, keeper_on});
      end
    end
    keep_always = 1'b1; #1;
    checks++;
    if ({sdout_oe, keeper_on} !== 2'b01) begin
      fails++;
      $display("FAIL R12 forced keeper: got %b expected 01", {sdout_oe, keeper_on});
    end
    keep_always = 1'b0;

    // R3/R6: single-slot streams, zero fill, offset 0
    tx_fall = 0; fill_hiz = 0; tx_offset = 0;
    stream_en = 4'b1110; temp_idx = 0; gain_idx = 2; boost_idx = 3;
    set_vals(10'h000, 8'hA5, 8'h3C, 8'h81);
    frame(40, "R6", 0);
    // R2: offset moves everything
    tx_offset = 5;
    frame(45, "R2", 0);
    // R4: narrow voltage
    tx_offset = 1; stream_en = 4'b0001; volt_idx = 1;
    set_vals(10'h2B5, 0, 0, 0);
    frame(30, "R4", 0);
    // R5: wide voltage
    volt_wide = 1;
    frame(30, "R5", 0);
    // R11: same with falling transmit edge
    tx_fall = 1;
    frame(30, "R11", 0);
    // R7/R8: only gain enabled, released fill
    fill_hiz = 1; volt_wide = 0; stream_en = 4'b0100;
    volt_idx = 0; temp_idx = 1; gain_idx = 2; boost_idx = 3;
    set_vals(10'h3FF, 8'hFF, 8'h96, 8'hFF);
    frame(40, "R7", 0);
    fill_hiz = 0;
    frame(40, "R8", 0);
    // R9: overlaps
    fill_hiz = 1; stream_en = 4'b1111; volt_wide = 1;
    volt_idx = 2; temp_idx = 3; gain_idx = 3; boost_idx = 1;
    set_vals(10'h155, 8'hF0, 8'h0F, 8'hC3);
    frame(40, "R9", 0);
    stream_en = 4'b0110;
    frame(40, "R9", 0);
    // R10: transmission cut at frame boundary
    stream_en = 4'b0001; volt_idx = 1; tx_offset = 1;
    set_vals(10'h3FF, 0, 0, 0);
    frame(16, "R10", 0);
    stream_en = 4'b0010; temp_idx = 4;
    frame(45, "R10", 0);
    // R12: keeper windows, both edges, full and half hold
    stream_en = 4'b0110; temp_idx = 1; gain_idx = 3; fill_hiz = 1;
    set_vals(0, 8'h01, 8'hFE, 0);
    for (int m = 0; m < 4; m++) begin
      tx_fall = m[0]; keep_half = m[1];
      frame(40, "R12", 0);
    end
    keep_en = 0;
    frame(40, "R12", 0);
    keep_en = 1; keep_half = 0;
    // R1: values captured at frame start
    stream_en = 4'b1111; volt_wide = 0;
    volt_idx = 0; temp_idx = 1; gain_idx = 2; boost_idx = 3;
    set_vals(10'h1C7, 8'h5A, 8'hC3, 8'h7E);
    frame(50, "R1", 1);

    // R3: random configurations
    for (int k = 0; k < 30; k++) begin
      tx_fall = 1'($urandom); tx_offset = 3'($urandom);
      volt_idx = 6'($urandom % 16); temp_idx = 6'($urandom % 16);
      gain_idx = 6'($urandom % 16); boost_idx = 6'($urandom % 16);
      stream_en = 4'($urandom); volt_wide = 1'($urandom); fill_hiz = 1'($urandom);
      keep_en = 1'($urandom); keep_always = (($urandom % 4) == 0);
      keep_half = 1'($urandom);
      set_vals(10'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      frame(24 + int'($urandom % 140), "R3", 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule